// File: doc/BRIEF.md
# Mode-Aware Load Formatter and Right Shifter

This block is one execution slice of a 64-bit core that must also run code written for an older 32-bit machine. Each cycle it may accept one operation together with the current machine mode (32-bit or 64-bit), a two-bit operation class, an operand-width bit, a 64-bit data word and a shift amount. It returns either a formatted 64-bit result or an illegal-instruction trap.

It handles two kinds of work. For loads, it formats a loaded 32-bit word into a 64-bit register value. Whether that word is sign-extended or zero-extended depends on the machine mode. A 64-bit load passes the whole word through. For right shifts, the operand width comes from the instruction, not from the mode. That width decides which bit is the sign source and how many bits of the shift amount are used.

Operations that exist only in 64-bit form are screened against the machine mode. When one is issued in 32-bit mode, the block flags a trap instead of producing a result. Results and traps appear exactly one clock after the input is accepted.

Top module: `wide_compat_slice`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, `res_valid`, `res_trap` and `res_data` are all zero until a new operation completes.
- R2: An operation accepted with `in_valid` high at one edge produces exactly one output pulse at the next edge, on `res_valid` or on `res_trap`, never on both. Back-to-back inputs give back-to-back outputs.
- R3: Class 2'b00 (32-bit load) with `mode64` = 1 yields bits [31:0] of `in_data`, sign-extended from bit 31. Bits [63:32] of the input are ignored.
- R4: Class 2'b00 with `mode64` = 0 yields bits [31:0] of `in_data` with zeros in bits [63:32]. Bits [63:32] of the input are ignored.
- R5: Class 2'b01 (64-bit load) with `mode64` = 1 yields `in_data` unchanged.
- R6: Class 2'b10 (logical right shift) always fills with zeros. With `op_wide` = 1 it shifts all 64 bits by `shamt[5:0]`. With `op_wide` = 0 it shifts `{32'b0, in_data[31:0]}` by `shamt[4:0]`, and `shamt[5]` is ignored.
- R7: Class 2'b11 (arithmetic right shift) with `op_wide` = 0 first extends bit 31 into bits [63:32], then shifts by `shamt[4:0]`. The result stays sign-extended from bit 31.
- R8: Class 2'b11 with `op_wide` = 1 shifts all 64 bits by `shamt[5:0]`, filling from bit 63.
- R9: With `mode64` = 0, class 2'b01, or class 2'b10/2'b11 with `op_wide` = 1, raises `res_trap` for one cycle. In that cycle `res_valid` stays low and `res_data` keeps its previous value.
- R10: With `mode64` = 1 no operation traps. With `mode64` = 0, 32-bit loads and 32-bit-width shifts do not trap. `op_wide` has no effect on a 32-bit load.
- R11: A cycle with `in_valid` low raises neither output flag, and `res_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| mode64 | input | 1 | Machine mode: 1 = 64-bit, 0 = 32-bit |
| op_class | input | 2 | 00 load 32, 01 load 64, 10 logical right shift, 11 arithmetic right shift |
| op_wide | input | 1 | Shift operand width from the instruction: 1 = 64-bit, 0 = 32-bit |
| in_data | input | 64 | Loaded word or shift source |
| shamt | input | 6 | Shift amount |
| res_valid | output | 1 | One-cycle result strobe |
| res_trap | output | 1 | One-cycle illegal-instruction strobe |
| res_data | output | 64 | Registered result |

## Verification
32-bit loads are driven in both modes with a low word whose bit 31 is set and one whose bit 31 is clear. The upper input half holds a distinct pattern, so sign extension, zero extension and leakage of unused bits give three different results.

Shifts use amounts of 0, a small value, the maximum, and an amount with bit 5 set on a 32-bit operand. These show whether the amount mask and the fill source (bit 31, bit 63 or zero) are chosen by the width bit.

Trap cases are paired with the same operation in the other mode, and with the width bit toggled on a 32-bit load. This separates a mode-based screen from one that looks at the wrong field. Back-to-back and idle cycles separate one-cycle latency from held or stretched strobes.

// File: rtl/wce_pkg.sv
package wce_pkg;
  typedef enum logic [1:0] {
    OPC_LD_HALF = 2'b00,
    OPC_LD_FULL = 2'b01,
    OPC_SH_LOG  = 2'b10,
    OPC_SH_ARI  = 2'b11
  } opc_e;

  function automatic logic opc_is_shift(input logic [1:0] opc);
    return (opc == OPC_SH_LOG) || (opc == OPC_SH_ARI);
  endfunction
endpackage

// File: rtl/wce_load_fmt.sv
module wce_load_fmt
  import wce_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HALF_W = 32
) (
  input  logic [1:0]        opc,
  input  logic              mode64,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] fmt
);
  localparam int EXT_W = DATA_W - HALF_W;

  logic ext_bit;

  // Sign source only in wide mode; legacy mode keeps upper bits clear.
  assign ext_bit = mode64 & word[HALF_W-1];

  always_comb begin
    if (opc == OPC_LD_FULL) begin
      fmt = word;
    end else begin
      fmt = {{EXT_W{ext_bit}}, word[HALF_W-1:0]};
    end
  end
endmodule

// File: rtl/wce_rshift.sv
module wce_rshift #(
  parameter int DATA_W = 64,
  parameter int HALF_W = 32,
  localparam int SHW   = $clog2(DATA_W),
  localparam int HSHW  = $clog2(HALF_W)
) (
  input  logic              arith,
  input  logic              wide,
  input  logic [DATA_W-1:0] src,
  input  logic [SHW-1:0]    amt,
  output logic [DATA_W-1:0] res
);
  localparam int EXT_W = DATA_W - HALF_W;

  logic              fill;
  logic [DATA_W-1:0] prep;
  logic [SHW-1:0]    eff_amt;
  logic [DATA_W-1:0] stage [SHW+1];

  assign fill    = arith & (wide ? src[DATA_W-1] : src[HALF_W-1]);
  assign prep    = wide ? src : {{EXT_W{fill}}, src[HALF_W-1:0]};
  assign eff_amt = wide ? amt : {{(SHW-HSHW){1'b0}}, amt[HSHW-1:0]};
  assign stage[0] = prep;

  // Log-depth barrel: stage s shifts by 2**s when amount bit s is set.
  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = eff_amt[s] ? {{STEP{fill}}, stage[s][DATA_W-1:STEP]}
                                   : stage[s];
  end

  assign res = stage[SHW];
endmodule

// File: rtl/wce_trap_screen.sv
module wce_trap_screen
  import wce_pkg::*;
(
  input  logic       mode64,
  input  logic [1:0] opc,
  input  logic       wide,
  output logic       illegal
);
  logic needs_wide;

  assign needs_wide = (opc == OPC_LD_FULL) | (opc_is_shift(opc) & wide);
  assign illegal    = needs_wide & ~mode64;
endmodule

// File: rtl/wide_compat_slice.sv
module wide_compat_slice
  import wce_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HALF_W = 32,
  localparam int SHW   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              mode64,
  input  logic [1:0]        op_class,
  input  logic              op_wide,
  input  logic [DATA_W-1:0] in_data,
  input  logic [SHW-1:0]    shamt,
  output logic              res_valid,
  output logic              res_trap,
  output logic [DATA_W-1:0] res_data
);
  logic [DATA_W-1:0] ld_res;
  logic [DATA_W-1:0] sh_res;
  logic [DATA_W-1:0] nxt_res;
  logic              illegal;

  wce_load_fmt #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_ld (
    .opc    (op_class),
    .mode64 (mode64),
    .word   (in_data),
    .fmt    (ld_res)
  );

  wce_rshift #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_sh (
    .arith (op_class == OPC_SH_ARI),
    .wide  (op_wide),
    .src   (in_data),
    .amt   (shamt),
    .res   (sh_res)
  );

  wce_trap_screen u_trap (
    .mode64  (mode64),
    .opc     (op_class),
    .wide    (op_wide),
    .illegal (illegal)
  );

  assign nxt_res = opc_is_shift(op_class) ? sh_res : ld_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_trap  <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= in_valid & ~illegal;
      res_trap  <= in_valid & illegal;
      if (in_valid && !illegal) begin
        res_data <= nxt_res;
      end
    end
  end
endmodule

// File: rtl/wide_compat_slice_chk.sv
module wide_compat_slice_chk #(
  parameter int DATA_W = 64,
  parameter int HALF_W = 32,
  localparam int SHW   = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              mode64,
  input logic [1:0]        op_class,
  input logic              op_wide,
  input logic [DATA_W-1:0] in_data,
  input logic [SHW-1:0]    shamt,
  input logic              res_valid,
  input logic              res_trap,
  input logic [DATA_W-1:0] res_data
);
  localparam int EXT_W = DATA_W - HALF_W;

  p_one_flag_r2: assert property (@(posedge clk) disable iff (rst)
    !(res_valid && res_trap));

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (res_valid || res_trap));

  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!res_valid && !res_trap && $stable(res_data)));

  p_sext_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode64 && op_class == 2'b00)
      |=> (res_data[DATA_W-1:HALF_W] == {EXT_W{$past(in_data[HALF_W-1])}}));

  p_zext_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mode64 && op_class == 2'b00)
      |=> (res_data[DATA_W-1:HALF_W] == '0));

  p_srl_half_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_class == 2'b10 && !op_wide)
      |=> (res_data[DATA_W-1:HALF_W] == '0));

  p_sra_half_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_class == 2'b11 && !op_wide)
      |=> (res_data[DATA_W-1:HALF_W] == {EXT_W{res_data[HALF_W-1]}}));

  p_trap_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mode64 && (op_class == 2'b01 || (op_class[1] && op_wide)))
      |=> (res_trap && $stable(res_data)));

  p_no_trap_wide_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode64) |=> !res_trap);
endmodule

bind wide_compat_slice wide_compat_slice_chk #(.DATA_W(DATA_W), .HALF_W(HALF_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .mode64    (mode64),
  .op_class  (op_class),
  .op_wide   (op_wide),
  .in_data   (in_data),
  .shamt     (shamt),
  .res_valid (res_valid),
  .res_trap  (res_trap),
  .res_data  (res_data)
);

// File: tb/wide_compat_slice_tb_top.sv
`timescale 1ns/1ps
module wide_compat_slice_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        mode64;
  logic [1:0]  op_class;
  logic        op_wide;
  logic [63:0] in_data;
  logic [5:0]  shamt;
  logic        res_valid;
  logic        res_trap;
  logic [63:0] res_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  wide_compat_slice dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode64(mode64),
    .op_class(op_class), .op_wide(op_wide), .in_data(in_data), .shamt(shamt),
    .res_valid(res_valid), .res_trap(res_trap), .res_data(res_data)
  );

  task automatic check(input string req, input logic v, input logic t, input logic [63:0] d);
    n_cmp++;
    if (res_valid !== v || res_trap !== t || res_data !== d) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b trap=%0b data=%h, expected valid=%0b trap=%0b data=%h",
               req, res_valid, res_trap, res_data, v, t, d);
    end
  endtask

  // Drive for one edge; outputs are sampled at the following falling edge.
  task automatic issue(input logic m, input logic [1:0] o, input logic w,
                       input logic [63:0] a, input logic [5:0] s);
    @(negedge clk);
    in_valid = 1'b1; mode64 = m; op_class = o; op_wide = w; in_data = a; shamt = s;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 reset", 1'b0, 1'b0, 64'h0);
  endtask

  task automatic t_load_half;
    issue(1'b1, 2'b00, 1'b0, 64'hDEAD_BEEF_8000_1234, 6'd0);
    check("R3 sext neg", 1'b1, 1'b0, 64'hFFFF_FFFF_8000_1234);
    issue(1'b1, 2'b00, 1'b0, 64'hFFFF_0000_7654_3210, 6'd0);
    check("R3 sext pos", 1'b1, 1'b0, 64'h0000_0000_7654_3210);
    issue(1'b0, 2'b00, 1'b0, 64'hDEAD_BEEF_8000_1234, 6'd0);
    check("R4 zext", 1'b1, 1'b0, 64'h0000_0000_8000_1234);
    issue(1'b0, 2'b00, 1'b1, 64'h1234_5678_F00D_CAFE, 6'd0);
    check("R10 width bit ignored on 32-bit load", 1'b1, 1'b0, 64'h0000_0000_F00D_CAFE);
  endtask

  task automatic t_load_full;
    issue(1'b1, 2'b01, 1'b0, 64'h8123_4567_89AB_CDEF, 6'd0);
    check("R5 full load", 1'b1, 1'b0, 64'h8123_4567_89AB_CDEF);
  endtask

  task automatic t_logical;
    issue(1'b1, 2'b10, 1'b1, 64'hF000_0000_0000_0000, 6'd4);
    check("R6 srl64 by 4", 1'b1, 1'b0, 64'h0F00_0000_0000_0000);
    issue(1'b1, 2'b10, 1'b1, 64'h8000_0000_0000_0000, 6'd63);
    check("R6 srl64 by 63", 1'b1, 1'b0, 64'h1);
    issue(1'b0, 2'b10, 1'b0, 64'hFFFF_FFFF_8000_0000, 6'd37);
    check("R6 srl32 amount masked", 1'b1, 1'b0, 64'h0000_0000_0400_0000);
    issue(1'b1, 2'b10, 1'b0, 64'hAAAA_AAAA_9000_0001, 6'd0);
    check("R6 srl32 by 0", 1'b1, 1'b0, 64'h0000_0000_9000_0001);
  endtask

  task automatic t_arith;
    issue(1'b0, 2'b11, 1'b0, 64'h0000_0000_8000_0000, 6'd31);
    check("R7 sra32 by 31", 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    issue(1'b1, 2'b11, 1'b0, 64'h7FFF_FFFF_F000_0010, 6'd36);
    check("R7 sra32 masked", 1'b1, 1'b0, 64'hFFFF_FFFF_FF00_0001);
    issue(1'b1, 2'b11, 1'b0, 64'hFFFF_FFFF_4000_0000, 6'd2);
    check("R7 sra32 positive", 1'b1, 1'b0, 64'h0000_0000_1000_0000);
    issue(1'b1, 2'b11, 1'b1, 64'h8000_0000_0000_0000, 6'd63);
    check("R8 sra64 by 63", 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    issue(1'b1, 2'b11, 1'b1, 64'h0000_0000_8000_0000, 6'd4);
    check("R8 sra64 no bit31 fill", 1'b1, 1'b0, 64'h0000_0000_0800_0000);
  endtask

  task automatic t_trap;
    issue(1'b1, 2'b01, 1'b0, 64'h0123_4567_89AB_CDEF, 6'd0);
    check("R9 setup", 1'b1, 1'b0, 64'h0123_4567_89AB_CDEF);
    issue(1'b0, 2'b01, 1'b0, 64'h5555_5555_5555_5555, 6'd0);
    check("R9 full load in 32-bit mode", 1'b0, 1'b1, 64'h0123_4567_89AB_CDEF);
    issue(1'b0, 2'b11, 1'b1, 64'h5555_5555_5555_5555, 6'd1);
    check("R9 wide sra in 32-bit mode", 1'b0, 1'b1, 64'h0123_4567_89AB_CDEF);
    issue(1'b0, 2'b10, 1'b1, 64'h5555_5555_5555_5555, 6'd1);
    check("R9 wide srl in 32-bit mode", 1'b0, 1'b1, 64'h0123_4567_89AB_CDEF);
    @(negedge clk);
    check("R9 trap lasts one cycle", 1'b0, 1'b0, 64'h0123_4567_89AB_CDEF);
    issue(1'b1, 2'b10, 1'b1, 64'h5555_5555_5555_5555, 6'd1);
    check("R10 wide srl in 64-bit mode", 1'b1, 1'b0, 64'h2AAA_AAAA_AAAA_AAAA);
  endtask

  task automatic t_pipe;
    @(negedge clk);
    in_valid = 1'b1; mode64 = 1'b1; op_class = 2'b00; op_wide = 1'b0;
    in_data = 64'h0000_0000_8000_0001; shamt = 6'd0;
    @(negedge clk);
    check("R2 first of pair", 1'b1, 1'b0, 64'hFFFF_FFFF_8000_0001);
    mode64 = 1'b0;
    @(negedge clk);
    check("R2 second of pair", 1'b1, 1'b0, 64'h0000_0000_8000_0001);
    in_valid = 1'b0; in_data = 64'h7777_7777_7777_7777;
    @(negedge clk);
    check("R11 idle no strobe", 1'b0, 1'b0, 64'h0000_0000_8000_0001);
    @(negedge clk);
    check("R11 idle data held", 1'b0, 1'b0, 64'h0000_0000_8000_0001);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; mode64 = 1'b0; op_class = 2'b00;
    op_wide = 1'b0; in_data = '0; shamt = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_load_half();
    t_load_full();
    t_logical();
    t_arith();
    t_trap();
    t_pipe();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule